// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Register

This block stores the divider settings of a frequency synthesizer: a 9-bit feedback divider value, a 2-bit code that selects the output divider, and a 3-bit test field. Settings arrive in one of two ways. A slow three-wire serial port shifts bits into a 14-bit chain and moves the chain into the output registers on a load strobe. A parallel path copies the divider value and divider code from dedicated pins whenever its enable is high.

All three serial pins are treated as asynchronous. They pass through a synchronizer of configurable depth on the system clock, and rising edges of the synchronized serial clock and load strobe act as one-cycle events. The output registers change only on a load. A registered flag reports whether the stored divider value lies in the window where the loop can lock.

Top module: `cfg_serpar_reg`

## Requirements
- R1: While rst_ni is low and after its release, m_o = 400, n_o = 2'b00, test_o = 3'b000 and m_legal_o = 1, until the first load.
- R2: Each rising edge of ser_clk_i shifts ser_data_i into the chain. The bits go in test field first, then the N code, then M, each MSB first. After 14 shifts and a strobe, the last 9 bits sent appear on m_o, the 2 before them on n_o and the first 3 on test_o. For example, M = 262 is sent as 100000110, and the N code 01 (divide by four) appears unchanged on n_o.
- R3: Shifting without a load event leaves m_o, n_o and test_o unchanged.
- R4: A rising edge of ser_load_i copies the chain into the outputs once. Holding the strobe high causes no further copy.
- R5: While par_load_i is high, m_o and n_o follow par_m_i and par_n_i one clock later. test_o keeps its value.
- R6: When a serial load edge occurs while par_load_i is high, the parallel values win.
- R7: m_legal_o is 1 exactly when 200 <= m_o <= 400.
- R8: A parallel load does not disturb the serial chain. A later strobe still loads the bits shifted in earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial transfer strobe, rising-edge active |
| par_load_i | input | 1 | Parallel capture enable, level active |
| par_m_i | input | 9 | Parallel M value |
| par_n_i | input | 2 | Parallel N code |
| m_o | output | 9 | Stored M value |
| n_o | output | 2 | Stored N code |
| test_o | output | 3 | Stored test field |
| m_legal_o | output | 1 | M inside the lock window |

## Verification
The bench builds the block with its default parameters: field widths 9/2/3, a window of 200 to 400, a reset value of 400 and a two-stage synchronizer. These values put the window edges 199, 200, 400 and 401 within reach of the parallel pins. The full 9-bit code space covers values below, inside and above the window. Serial pins are held for several system clocks per phase, so the checks do not depend on the synchronizer depth.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned M_W_DEF   = 9;
  localparam int unsigned N_W_DEF   = 2;
  localparam int unsigned T_W_DEF   = 3;
  localparam int unsigned M_MIN_DEF = 200;
  localparam int unsigned M_MAX_DEF = 400;
  localparam int unsigned M_RST_DEF = 400;
  localparam int unsigned SYNC_DEF  = 2;

  function automatic logic in_range(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  generate
    if (STAGES <= 1) begin : g_one
      logic [W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_multi
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= q_o;
  end

  assign rise_o = q_o & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned LEN = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_en_i,
  input  logic           din_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[LEN-2:0], din_i};
  end

  assign q_o = sr_q;
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import cfg_pkg::*;
#(
  parameter int unsigned M_W   = M_W_DEF,
  parameter int unsigned N_W   = N_W_DEF,
  parameter int unsigned T_W   = T_W_DEF,
  parameter int unsigned M_MIN = M_MIN_DEF,
  parameter int unsigned M_MAX = M_MAX_DEF,
  parameter int unsigned M_RST = M_RST_DEF,
  localparam int unsigned LEN  = M_W + N_W + T_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_en_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_en_i,
  input  logic [LEN-1:0] word_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           legal_o
);
  localparam logic [M_W-1:0] M_RST_V = M_RST[M_W-1:0];

  logic [M_W-1:0] m_q, m_d;
  logic [N_W-1:0] n_q, n_d;
  logic [T_W-1:0] t_q, t_d;
  logic           legal_q;

  // parallel path wins over serial transfer
  always_comb begin
    m_d = m_q;
    n_d = n_q;
    t_d = t_q;
    if (par_en_i) begin
      m_d = par_m_i;
      n_d = par_n_i;
    end else if (ser_en_i) begin
      m_d = word_i[M_W-1:0];
      n_d = word_i[M_W +: N_W];
      t_d = word_i[M_W+N_W +: T_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q     <= M_RST_V;
      n_q     <= '0;
      t_q     <= '0;
      legal_q <= in_range(M_RST, M_MIN, M_MAX);
    end else begin
      m_q     <= m_d;
      n_q     <= n_d;
      t_q     <= t_d;
      legal_q <= in_range(int'(m_d), M_MIN, M_MAX);
    end
  end

  assign m_o     = m_q;
  assign n_o     = n_q;
  assign t_o     = t_q;
  assign legal_o = legal_q;
endmodule

// File: rtl/cfg_serpar_reg.sv
module cfg_serpar_reg
  import cfg_pkg::*;
#(
  parameter int unsigned M_W         = M_W_DEF,
  parameter int unsigned N_W         = N_W_DEF,
  parameter int unsigned T_W         = T_W_DEF,
  parameter int unsigned M_MIN       = M_MIN_DEF,
  parameter int unsigned M_MAX       = M_MAX_DEF,
  parameter int unsigned M_RST       = M_RST_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           par_load_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] test_o,
  output logic           m_legal_o
);
  localparam int unsigned LEN = M_W + N_W + T_W;

  logic [2:0]     pins_q, pins_rise;
  logic           shift_evt, ld_rise;
  logic [LEN-1:0] shift_q;

  // bit0 data, bit1 serial clock, bit2 strobe
  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_load_i, ser_clk_i, ser_data_i}),
    .q_o    (pins_q),
    .rise_o (pins_rise)
  );

  assign shift_evt = pins_rise[1];
  assign ld_rise   = pins_rise[2];

  cfg_shift #(.LEN(LEN)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_evt),
    .din_i      (pins_q[0]),
    .q_o        (shift_q)
  );

  cfg_hold #(
    .M_W(M_W), .N_W(N_W), .T_W(T_W),
    .M_MIN(M_MIN), .M_MAX(M_MAX), .M_RST(M_RST)
  ) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .par_en_i (par_load_i),
    .par_m_i  (par_m_i),
    .par_n_i  (par_n_i),
    .ser_en_i (ld_rise),
    .word_i   (shift_q),
    .m_o      (m_o),
    .n_o      (n_o),
    .t_o      (test_o),
    .legal_o  (m_legal_o)
  );
endmodule

// File: rtl/cfg_serpar_chk.sv
module cfg_serpar_chk #(
  parameter int unsigned M_W   = 9,
  parameter int unsigned N_W   = 2,
  parameter int unsigned T_W   = 3,
  parameter int unsigned M_MIN = 200,
  parameter int unsigned M_MAX = 400,
  parameter int unsigned M_RST = 400,
  localparam int unsigned LEN  = M_W + N_W + T_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           par_load_i,
  input logic [M_W-1:0] par_m_i,
  input logic [N_W-1:0] par_n_i,
  input logic           ld_rise,
  input logic [LEN-1:0] shift_q,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] test_o,
  input logic           m_legal_o
);
  // R1
  reset_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (m_o == M_RST[M_W-1:0]) && (n_o == '0) && (test_o == '0));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_load_i && !ld_rise) |=> $stable(m_o) && $stable(n_o) && $stable(test_o));

  // R4
  ser_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rise && !par_load_i) |=> (m_o == $past(shift_q[M_W-1:0]))
      && (n_o == $past(shift_q[M_W +: N_W])) && (test_o == $past(shift_q[M_W+N_W +: T_W])));

  // R5
  par_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_load_i |=> (m_o == $past(par_m_i)) && (n_o == $past(par_n_i)) && $stable(test_o));

  // R7
  legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_legal_o == ((int'(m_o) >= M_MIN) && (int'(m_o) <= M_MAX)));
endmodule

bind cfg_serpar_reg cfg_serpar_chk #(
  .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_MIN(M_MIN), .M_MAX(M_MAX), .M_RST(M_RST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_load_i (par_load_i),
  .par_m_i    (par_m_i),
  .par_n_i    (par_n_i),
  .ld_rise    (ld_rise),
  .shift_q    (shift_q),
  .m_o        (m_o),
  .n_o        (n_o),
  .test_o     (test_o),
  .m_legal_o  (m_legal_o)
);

// File: tb/sim_cfg_serpar_reg.sv
`timescale 1ns/1ps
module sim_cfg_serpar_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_load_i = 1'b0, par_load_i = 1'b0;
  logic [8:0] par_m_i = '0;
  logic [1:0] par_n_i = '0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] test_o;
  logic       m_legal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cfg_serpar_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i),
    .ser_load_i(ser_load_i), .par_load_i(par_load_i), .par_m_i(par_m_i), .par_n_i(par_n_i),
    .m_o(m_o), .n_o(n_o), .test_o(test_o), .m_legal_o(m_legal_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic ser_bit(input logic b);
    ser_data_i = b; wt(4);
    ser_clk_i = 1'b1; wt(4);
    ser_clk_i = 1'b0; wt(4);
  endtask

  task automatic ser_word(input logic [8:0] m, input logic [1:0] n, input logic [2:0] t);
    for (int i = 2; i >= 0; i--) ser_bit(t[i]);
    for (int i = 1; i >= 0; i--) ser_bit(n[i]);
    for (int i = 8; i >= 0; i--) ser_bit(m[i]);
  endtask

  task automatic strobe();
    ser_load_i = 1'b1; wt(4);
    ser_load_i = 1'b0; wt(6);
  endtask

  task automatic par_set(input logic [8:0] m, input logic [1:0] n);
    par_m_i = m; par_n_i = n; par_load_i = 1'b1; wt(3);
    par_load_i = 1'b0; wt(2);
  endtask

  task automatic t_reset();
    wt(3);
    chk("R1 m in reset", int'(m_o), 400);
    rst_ni = 1'b1; wt(3);
    chk("R1 m", int'(m_o), 400);
    chk("R1 n", int'(n_o), 0);
    chk("R1 test", int'(test_o), 0);
    chk("R1 legal", int'(m_legal_o), 1);
  endtask

  task automatic t_serial();
    ser_word(9'd262, 2'b01, 3'b101);
    chk("R3 m before strobe", int'(m_o), 400);
    chk("R3 n before strobe", int'(n_o), 0);
    strobe();
    chk("R2 m=262", int'(m_o), 9'b100000110);
    chk("R2 n code 01", int'(n_o), 1);
    chk("R2 test", int'(test_o), 5);
    chk("R7 legal 262", int'(m_legal_o), 1);
  endtask

  task automatic t_hold_and_edge();
    ser_word(9'd150, 2'b10, 3'b011);
    chk("R3 m held", int'(m_o), 262);
    chk("R3 test held", int'(test_o), 5);
    ser_load_i = 1'b1; wt(6);
    chk("R4 m on edge", int'(m_o), 150);
    chk("R7 legal 150", int'(m_legal_o), 0);
    par_set(9'd300, 2'b11);
    ser_load_i = 1'b1; wt(6);
    chk("R4 no reload while high", int'(m_o), 300);
    ser_load_i = 1'b0; wt(4);
  endtask

  task automatic t_parallel();
    par_set(9'd199, 2'b00);
    chk("R5 m", int'(m_o), 199);
    chk("R5 n", int'(n_o), 0);
    chk("R5 test kept", int'(test_o), 3);
    chk("R7 199", int'(m_legal_o), 0);
    par_set(9'd200, 2'b10); chk("R7 200", int'(m_legal_o), 1);
    chk("R5 n 10", int'(n_o), 2);
    par_set(9'd400, 2'b01); chk("R7 400", int'(m_legal_o), 1);
    par_set(9'd401, 2'b01); chk("R7 401", int'(m_legal_o), 0);
    par_set(9'd511, 2'b01); chk("R7 511", int'(m_legal_o), 0);
    par_set(9'd0, 2'b01);   chk("R7 0", int'(m_legal_o), 0);
  endtask

  task automatic t_priority();
    ser_word(9'd333, 2'b11, 3'b110);
    par_m_i = 9'd250; par_n_i = 2'b10; par_load_i = 1'b1; wt(2);
    ser_load_i = 1'b1; wt(6);
    ser_load_i = 1'b0; wt(2);
    par_load_i = 1'b0; wt(3);
    chk("R6 m par wins", int'(m_o), 250);
    chk("R6 n par wins", int'(n_o), 2);
    strobe();
    chk("R8 chain kept m", int'(m_o), 333);
    chk("R8 chain kept n", int'(n_o), 3);
    chk("R8 chain kept test", int'(test_o), 6);
  endtask

  initial begin
    t_reset();
    t_serial();
    t_hold_and_edge();
    t_parallel();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule